// File: doc/BRIEF.md
# Video Sync Control-Signal Conditioner

This block sits at the parallel input of a video serializer. Each pixel clock it takes one pixel word and the three video control lines: horizontal sync, vertical sync and data enable. It latches them on the rising or the falling edge of the pixel clock, as configuration selects. It then conditions the control lines before a downstream stage embeds them in the serial stream. When the glitch filter is selected, horizontal sync and data enable keep a new level only after that level has been held for a minimum number of clocks. Shorter pulses never reach the output.

The pixel word and vertical sync go through a delay line of the same depth as the filter, so that data and data enable leave the block together. The latency is the same in every mode. A rate monitor on each control line raises a sticky flag when the line toggles more often than its budget allows. Horizontal sync and data enable may toggle twice in any 130-clock span, and vertical sync once. The active-low power-down input returns every register to its reset value.

Top module: `vsf_ctl_cond`

## Requirements
- R1: With `mode` at 2'b00, 2'b10 or 2'b11 the filter is off, and `hs_out` and `de_out` equal the captured `hs_in` and `de_in` from exactly 4 rising edges after the cycle in which the input was presented.
- R2: With `mode` at 2'b01, an HS or DE pulse of 3 or more captured clocks appears at the output with the same width, 4 rising edges after it was presented.
- R3: With `mode` at 2'b01, an HS or DE pulse shorter than 3 captured clocks (high or low) leaves the output at its previous level.
- R4: `pix_out` and `vs_out` equal the captured `pix_in` and `vs_in` delayed by 4 rising edges in every mode. Vertical sync is never filtered.
- R5: With `rise_sel` at 1 the inputs are taken at the rising pixel-clock edge. With `rise_sel` at 0 they are taken at the preceding falling edge, and a change between that falling edge and the next rising edge is ignored. The latency is the same either way.
- R6: `viol_hs` (or `viol_de`) goes high 2 rising edges after a captured transition that comes fewer than 130 clocks after the transition two before it. A spacing of exactly 130 clocks does not set the flag.
- R7: `viol_vs` goes high 2 rising edges after a captured VS transition that comes fewer than 130 clocks after the previous VS transition. A spacing of 130 clocks does not set it.
- R8: Each violation flag, once set, stays high until `rst_n` or `pd_n` is asserted low.
- R9: While `pd_n` is low at a rising edge, every output is 0 after that edge, whatever the inputs are. All filter, delay and monitor state is cleared as well.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down, synchronous clear of all state |
| rise_sel | input | 1 | Capture edge: 1 rising, 0 falling |
| mode | input | 2 | Operating mode: 2'b01 enables the HS/DE filter |
| pix_in | input | PIX_W (24) | Pixel word input |
| hs_in | input | 1 | Horizontal sync input |
| vs_in | input | 1 | Vertical sync input |
| de_in | input | 1 | Data enable input |
| pix_out | output | PIX_W (24) | Delayed pixel word |
| hs_out | output | 1 | Conditioned horizontal sync |
| vs_out | output | 1 | Delayed vertical sync |
| de_out | output | 1 | Conditioned data enable |
| viol_hs | output | 1 | Sticky HS transition budget violation |
| viol_vs | output | 1 | Sticky VS transition budget violation |
| viol_de | output | 1 | Sticky DE transition budget violation |

## Verification
A value presented in cycle n is captured at rising edge n+1 and reaches the data and control outputs at rising edge n+4. A budget violation caused by that value shows on its flag at rising edge n+2. The bench drives inputs 5 ns after each rising edge and reads outputs 15 ns after it, which is past the falling edge. For the rising-capture runs it overwrites the inputs with their complement 16 ns after the edge, so the two capture edges see different values. The reference model indexes the stored input history with these fixed offsets (n-4 to n-2 for the filter window, n+2 for flags) and compares on every cycle, so an output that is early or late by even one edge is reported.

// File: rtl/vsf_pkg.sv
package vsf_pkg;

    typedef enum logic [1:0] {
        MODE_PASS  = 2'b00,
        MODE_FILT  = 2'b01,
        MODE_ALT_A = 2'b10,
        MODE_ALT_B = 2'b11
    } vsf_mode_e;

    function automatic logic filter_enabled(input logic [1:0] m);
        return vsf_mode_e'(m) == MODE_FILT;
    endfunction

endpackage

// File: rtl/vsf_capture.sv
module vsf_capture #(
    parameter int W = 27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pd_n,
    input  logic         rise_sel,
    input  logic [W-1:0] din,
    output logic [W-1:0] cap_q
);

    logic [W-1:0] fall_q, fall_d, cap_d;

    // Falling-edge sample is retimed into the rising-edge stage so that
    // both capture choices share one downstream latency.
    always_comb begin
        fall_d = pd_n ? din : '0;
        if (!pd_n) begin
            cap_d = '0;
        end else if (rise_sel) begin
            cap_d = din;
        end else begin
            cap_d = fall_q;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= '0;
        end else begin
            fall_q <= fall_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

endmodule

// File: rtl/vsf_pulse_filt.sv
module vsf_pulse_filt #(
    parameter int MIN_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    input  logic en,
    input  logic smp,
    output logic lvl_q
);

    localparam int HW = MIN_W - 1;

    typedef struct packed {
        logic [HW-1:0] hist;
        logic          lvl;
    } pf_st_t;

    pf_st_t st_q, st_d;
    logic   all_hi, all_lo;

    always_comb begin
        st_d         = st_q;
        all_hi       = smp & (&st_q.hist);
        all_lo       = ~(smp | (|st_q.hist));
        st_d.hist[0] = smp;
        for (int i = 1; i < HW; i++) begin
            st_d.hist[i] = st_q.hist[i-1];
        end
        if (en) begin
            // Level moves only when the whole window agrees.
            if (all_hi) begin
                st_d.lvl = 1'b1;
            end else if (all_lo) begin
                st_d.lvl = 1'b0;
            end
        end else begin
            // Bypass takes the oldest sample: same latency as the filter.
            st_d.lvl = st_q.hist[HW-1];
        end
        if (!pd_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_q = st_q.lvl;

endmodule

// File: rtl/vsf_rate_mon.sv
module vsf_rate_mon #(
    parameter int WIN = 130,
    parameter int BUD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    input  logic smp,
    output logic flag_q
);

    localparam int            CW  = $clog2(WIN);
    localparam logic [CW-1:0] SAT = CW'(WIN - 1);

    typedef struct packed {
        logic [BUD-1:0][CW-1:0] age;
        logic                   prev;
        logic                   flag;
    } rm_st_t;

    rm_st_t st_q, st_d;
    logic   toggle;

    function automatic logic [CW-1:0] bump(input logic [CW-1:0] a);
        return (a == SAT) ? SAT : a + 1'b1;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.prev = smp;
        toggle    = smp ^ st_q.prev;
        if (toggle) begin
            // Oldest tracked transition not yet a full window ago.
            if (st_q.age[BUD-1] != SAT) begin
                st_d.flag = 1'b1;
            end
            st_d.age[0] = '0;
            for (int i = 1; i < BUD; i++) begin
                st_d.age[i] = bump(st_q.age[i-1]);
            end
        end else begin
            for (int i = 0; i < BUD; i++) begin
                st_d.age[i] = bump(st_q.age[i]);
            end
        end
        if (!pd_n) begin
            st_d.age  = {BUD{SAT}};
            st_d.prev = 1'b0;
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.age  <= {BUD{SAT}};
            st_q.prev <= 1'b0;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_q = st_q.flag;

endmodule

// File: rtl/vsf_delay_line.sv
module vsf_delay_line #(
    parameter int W     = 25,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pd_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [DEPTH-1:0][W-1:0] stg_q, stg_d;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            stg_d[i] = stg_q[i-1];
        end
        if (!pd_n) begin
            stg_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[DEPTH-1];

endmodule

// File: rtl/vsf_ctl_cond.sv
module vsf_ctl_cond #(
    parameter int PIX_W     = 24,
    parameter int MIN_PULSE = 3,
    parameter int WIN_HD    = 130,
    parameter int WIN_VS    = 130,
    parameter int BUD_HD    = 2,
    parameter int BUD_VS    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             rise_sel,
    input  logic [1:0]       mode,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             hs_in,
    input  logic             vs_in,
    input  logic             de_in,
    output logic [PIX_W-1:0] pix_out,
    output logic             hs_out,
    output logic             vs_out,
    output logic             de_out,
    output logic             viol_hs,
    output logic             viol_vs,
    output logic             viol_de
);

    import vsf_pkg::*;

    localparam int CAP_W = PIX_W + 3;
    localparam int NFILT = 2;
    localparam int NMON  = 3;

    logic [CAP_W-1:0] cap_bus;
    logic [PIX_W-1:0] cap_pix;
    logic             cap_hs, cap_vs, cap_de;
    logic             filt_en;
    logic [NFILT-1:0] filt_in, filt_out;
    logic [NMON-1:0]  mon_in, mon_flag;

    vsf_capture #(.W(CAP_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_n     (pd_n),
        .rise_sel (rise_sel),
        .din      ({pix_in, hs_in, vs_in, de_in}),
        .cap_q    (cap_bus)
    );

    assign {cap_pix, cap_hs, cap_vs, cap_de} = cap_bus;
    assign filt_en = filter_enabled(mode);

    // Index 1: horizontal sync, index 0: data enable.
    assign filt_in = {cap_hs, cap_de};

    for (genvar g = 0; g < NFILT; g++) begin : g_filt
        vsf_pulse_filt #(.MIN_W(MIN_PULSE)) u_pf (
            .clk   (clk),
            .rst_n (rst_n),
            .pd_n  (pd_n),
            .en    (filt_en),
            .smp   (filt_in[g]),
            .lvl_q (filt_out[g])
        );
    end

    assign hs_out = filt_out[1];
    assign de_out = filt_out[0];

    vsf_delay_line #(.W(PIX_W + 1), .DEPTH(MIN_PULSE)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .pd_n  (pd_n),
        .din   ({cap_pix, cap_vs}),
        .dout  ({pix_out, vs_out})
    );

    // Index 2: horizontal sync, 1: vertical sync, 0: data enable.
    assign mon_in = {cap_hs, cap_vs, cap_de};

    for (genvar g = 0; g < NMON; g++) begin : g_mon
        localparam int MW = (g == 1) ? WIN_VS : WIN_HD;
        localparam int MB = (g == 1) ? BUD_VS : BUD_HD;
        vsf_rate_mon #(.WIN(MW), .BUD(MB)) u_rm (
            .clk    (clk),
            .rst_n  (rst_n),
            .pd_n   (pd_n),
            .smp    (mon_in[g]),
            .flag_q (mon_flag[g])
        );
    end

    assign viol_hs = mon_flag[2];
    assign viol_vs = mon_flag[1];
    assign viol_de = mon_flag[0];

endmodule

// File: rtl/vsf_ctl_cond_chk.sv
module vsf_ctl_cond_chk #(
    parameter int MIN_PULSE = 3,
    parameter int PIX_W     = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pd_n,
    input logic [1:0]       mode,
    input logic             cap_hs,
    input logic             cap_de,
    input logic             hs_out,
    input logic             vs_out,
    input logic             de_out,
    input logic [PIX_W-1:0] pix_out,
    input logic             viol_hs,
    input logic             viol_vs,
    input logic             viol_de
);

    localparam int            RW  = $clog2(MIN_PULSE + 1);
    localparam logic [RW-1:0] RMX = RW'(MIN_PULSE);

    logic [RW-1:0] run_hs_q, run_de_q;
    logic          last_hs_q, last_de_q;

    // Length of the current run of equal captured samples, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_hs_q  <= '0;
            run_de_q  <= '0;
            last_hs_q <= 1'b0;
            last_de_q <= 1'b0;
        end else begin
            last_hs_q <= cap_hs;
            last_de_q <= cap_de;
            run_hs_q  <= (cap_hs != last_hs_q) ? RW'(1) : ((run_hs_q == RMX) ? RMX : run_hs_q + 1'b1);
            run_de_q  <= (cap_de != last_de_q) ? RW'(1) : ((run_de_q == RMX) ? RMX : run_de_q + 1'b1);
        end
    end

    // R3: filtered HS changes only after a full-length run of samples
    a_r3_hs_min_run: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b01 && $past(pd_n) && hs_out != $past(hs_out)) |-> run_hs_q >= RMX);

    // R3: same for DE
    a_r3_de_min_run: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b01 && $past(pd_n) && de_out != $past(de_out)) |-> run_de_q >= RMX);

    // R8: flags hold while powered
    a_r8_hs_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_hs && pd_n) |=> viol_hs);
    a_r8_vs_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_vs && pd_n) |=> viol_vs);
    a_r8_de_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_de && pd_n) |=> viol_de);

    // R9: power-down clears every output at the next edge
    a_r9_pd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (!hs_out && !vs_out && !de_out && pix_out == '0
                   && !viol_hs && !viol_vs && !viol_de));

    // R7: VS flag can only rise while powered
    a_r7_vs_flag_powered: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol_vs) |-> $past(pd_n));

endmodule

bind vsf_ctl_cond vsf_ctl_cond_chk #(.MIN_PULSE(MIN_PULSE), .PIX_W(PIX_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pd_n    (pd_n),
    .mode    (mode),
    .cap_hs  (cap_hs),
    .cap_de  (cap_de),
    .hs_out  (hs_out),
    .vs_out  (vs_out),
    .de_out  (de_out),
    .pix_out (pix_out),
    .viol_hs (viol_hs),
    .viol_vs (viol_vs),
    .viol_de (viol_de)
);

// File: tb/sim_vsf_ctl_cond.sv
module sim_vsf_ctl_cond;

    localparam int PW   = 24;
    localparam int NMAX = 512;
    localparam int LAT  = 4;
    localparam int FLAT = 2;
    localparam int WIN  = 130;
    localparam int NEVR = 1 << 30;

    logic          clk, rst_n, pd_n, rise_sel;
    logic [1:0]    mode;
    logic [PW-1:0] pix_in, pix_out;
    logic          hs_in, vs_in, de_in;
    logic          hs_out, vs_out, de_out;
    logic          viol_hs, viol_vs, viol_de;

    vsf_ctl_cond u0 (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .rise_sel(rise_sel), .mode(mode),
        .pix_in(pix_in), .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
        .pix_out(pix_out), .hs_out(hs_out), .vs_out(vs_out), .de_out(de_out),
        .viol_hs(viol_hs), .viol_vs(viol_vs), .viol_de(viol_de)
    );

    bit            a_hs [NMAX];
    bit            a_vs [NMAX];
    bit            a_de [NMAX];
    logic [PW-1:0] a_pix[NMAX];
    bit            e_hs [NMAX];
    bit            e_vs [NMAX];
    bit            e_de [NMAX];
    logic [PW-1:0] e_pix[NMAX];
    int            plen;
    int            total = 0;
    int            bad   = 0;
    bit            done  = 0;

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int cyc,
                       input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s cycle %0d actual=%0h expected=%0h", req, what, cyc, act, exp);
        end
    endtask

    function automatic bit pick(input bit arr[NMAX], input int k);
        return (k < 0) ? 1'b0 : arr[k];
    endfunction

    function automatic logic [PW-1:0] pickp(input logic [PW-1:0] arr[NMAX], input int k);
        return (k < 0) ? '0 : arr[k];
    endfunction

    task automatic build_filter_pat();
        int p;
        p = 0;
        for (int w = 1; w <= 6; w++) begin
            for (int k = 0; k < w + 6; k++) begin
                a_hs[p] = (k < w);
                a_de[p] = (k < 7 - w);
                p++;
            end
        end
        for (int w = 1; w <= 6; w++) begin
            for (int k = 0; k < w + 6; k++) begin
                a_hs[p] = (k < 6);
                a_de[p] = (k < w);
                p++;
            end
        end
        for (int k = 0; k < 10; k++) begin
            a_hs[p] = 1'b0;
            a_de[p] = 1'b0;
            p++;
        end
        plen = p;
        for (int n = 0; n < plen; n++) begin
            a_vs[n]  = ((n / 37) % 2) == 1;
            a_pix[n] = PW'(n * 32'h0001_3579 + 7);
        end
    endtask

    task automatic build_rate_pat();
        int th[6] = '{0, 65, 130, 200, 265, 329};
        int td[3] = '{5, 70, 134};
        int tv[4] = '{10, 140, 300, 429};
        bit lh, ld, lv;
        lh = 0; ld = 0; lv = 0;
        plen = 460;
        for (int n = 0; n < plen; n++) begin
            foreach (th[i]) if (th[i] == n) lh = ~lh;
            foreach (td[i]) if (td[i] == n) ld = ~ld;
            foreach (tv[i]) if (tv[i] == n) lv = ~lv;
            a_hs[n]  = lh;
            a_de[n]  = ld;
            a_vs[n]  = lv;
            a_pix[n] = PW'(n * 32'h0000_0A31);
        end
    endtask

    task automatic run_section(input logic [1:0] m, input bit rs, input bit jk);
        bit    fh, fd, h4, h3, h2, d4, d3, d2;
        int    th1, th2, td1, td2, tv1;
        int    vh, vd, vv;
        string rq, rctl, rflg;
        fh = 0; fd = 0;
        th1 = -NEVR; th2 = -NEVR; td1 = -NEVR; td2 = -NEVR; tv1 = -NEVR;
        vh = NEVR; vd = NEVR; vv = NEVR;
        rctl = (m == 2'b01) ? "R2 R3" : "R1";
        if (!rs) rctl = {rctl, " R5"};
        rst_n = 0; pd_n = 1; mode = m; rise_sel = rs;
        hs_in = 0; vs_in = 0; de_in = 0; pix_in = '0;
        repeat (3) @(posedge clk);
        #5 rst_n = 1;
        for (int n = 0; n < plen; n++) begin
            @(posedge clk);
            #5;
            hs_in = a_hs[n]; vs_in = a_vs[n]; de_in = a_de[n]; pix_in = a_pix[n];
            e_hs[n]  = (rs && jk) ? ~a_hs[n] : a_hs[n];
            e_de[n]  = (rs && jk) ? ~a_de[n] : a_de[n];
            e_vs[n]  = (rs && jk) ? ~a_vs[n] : a_vs[n];
            e_pix[n] = (rs && jk) ? ~a_pix[n] : a_pix[n];
            // filter reference on the window n-4..n-2
            h4 = pick(e_hs, n - 4); h3 = pick(e_hs, n - 3); h2 = pick(e_hs, n - 2);
            d4 = pick(e_de, n - 4); d3 = pick(e_de, n - 3); d2 = pick(e_de, n - 2);
            if (m == 2'b01) begin
                if (h4 && h3 && h2) fh = 1; else if (!(h4 || h3 || h2)) fh = 0;
                if (d4 && d3 && d2) fd = 1; else if (!(d4 || d3 || d2)) fd = 0;
            end else begin
                fh = h4;
                fd = d4;
            end
            // transition budget reference
            if (e_hs[n] != pick(e_hs, n - 1)) begin
                if (n - th2 < WIN && vh == NEVR) vh = n + FLAT;
                th2 = th1; th1 = n;
            end
            if (e_de[n] != pick(e_de, n - 1)) begin
                if (n - td2 < WIN && vd == NEVR) vd = n + FLAT;
                td2 = td1; td1 = n;
            end
            if (e_vs[n] != pick(e_vs, n - 1)) begin
                if (n - tv1 < WIN && vv == NEVR) vv = n + FLAT;
                tv1 = n;
            end
            #10;
            rq   = (n < LAT) ? "R10" : rctl;
            rflg = (n < LAT) ? "R10" : "R8";
            chk(rq, "hs_out", n, hs_out, fh);
            chk(rq, "de_out", n, de_out, fd);
            chk((n < LAT) ? "R10" : (rs ? "R4" : "R4 R5"), "vs_out", n, vs_out, pick(e_vs, n - 4));
            chk((n < LAT) ? "R10" : (rs ? "R4" : "R4 R5"), "pix_out", n, pix_out, pickp(e_pix, n - 4));
            chk({"R6 ", rflg}, "viol_hs", n, viol_hs, vh <= n);
            chk({"R6 ", rflg}, "viol_de", n, viol_de, vd <= n);
            chk({"R7 ", rflg}, "viol_vs", n, viol_vs, vv <= n);
            #1;
            if (jk) begin
                hs_in = ~a_hs[n]; vs_in = ~a_vs[n]; de_in = ~a_de[n]; pix_in = ~a_pix[n];
            end
        end
    endtask

    task automatic pd_test();
        @(posedge clk);
        #5;
        pd_n = 0; hs_in = 1; vs_in = 1; de_in = 1; pix_in = '1;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk);
            #15;
            chk("R9", "hs_out", k, hs_out, 0);
            chk("R9", "de_out", k, de_out, 0);
            chk("R9", "vs_out", k, vs_out, 0);
            chk("R9", "pix_out", k, pix_out, 0);
            chk("R8 R9", "viol_hs", k, viol_hs, 0);
            chk("R8 R9", "viol_de", k, viol_de, 0);
            chk("R8 R9", "viol_vs", k, viol_vs, 0);
        end
        @(posedge clk);
        #5;
        pd_n = 1; hs_in = 0; vs_in = 0; de_in = 0; pix_in = '0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk);
            #15;
            chk("R9", "hs_out after wake", k, hs_out, 0);
            chk("R9", "pix_out after wake", k, pix_out, 0);
            chk("R8", "viol_hs after wake", k, viol_hs, 0);
            chk("R8", "viol_vs after wake", k, viol_vs, 0);
            chk("R8", "viol_de after wake", k, viol_de, 0);
        end
    endtask

    initial begin
        rst_n = 0; pd_n = 1; rise_sel = 1; mode = 2'b00;
        hs_in = 0; vs_in = 0; de_in = 0; pix_in = '0;
        build_filter_pat();
        run_section(2'b00, 1'b1, 1'b1);
        run_section(2'b01, 1'b1, 1'b1);
        run_section(2'b10, 1'b1, 1'b1);
        run_section(2'b11, 1'b1, 1'b0);
        run_section(2'b01, 1'b0, 1'b1);
        run_section(2'b00, 1'b0, 1'b1);
        build_rate_pat();
        run_section(2'b01, 1'b1, 1'b0);
        pd_test();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule